// File: doc/BRIEF.md
# Four-Line External Interrupt Trigger Controller

This block takes four asynchronous interrupt pins and turns them into one interrupt request for the processor. Each pin gets its own trigger rule. It can fire on a high or low level, on a rising or falling edge, or on any edge. The block records a pending status bit for each line. Lines that software has enabled are combined into the request output.

All controls and all status sit in a single 32-bit word behind a plain write-strobe and read-data port. The word holds six four-bit groups: sense, status, clear, enable, any-edge and level-select. A build parameter chooses between two packings of that word. In the compact packing the groups begin every 4 bits. In the spread packing they begin every 5 bits.

Software reads the word to learn which lines are pending. It acknowledges edge events by writing ones to the clear group. Writing ones to every clear bit while zeroing every enable bit silences the whole block in one access.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every bit of `cfg_rdata` is 0 and `irq_out` is 0. Bits outside the six groups always read 0.
- R2: Group g (sense=0, status=1, clear=2, enable=3, any-edge=4, level-select=5) holds line i at bit g*4+i when `ALT_LAYOUT`=0, and at bit g*5+i when `ALT_LAYOUT`=1. A write with `cfg_we`=1 loads the sense, enable, any-edge and level-select groups, and they read back from the next cycle on. Writes to the status group are ignored.
- R3: A line with level-select=1 and sense=1 shows status 1 exactly while its synchronized pin is high.
- R4: A line with level-select=1 and sense=0 shows status 1 exactly while its synchronized pin is low.
- R5: With level-select=0, any-edge=0 and sense=1, a rising pin edge sets status. The status then stays set through later pin changes until it is cleared.
- R6: With level-select=0, any-edge=0 and sense=0, a falling pin edge sets a sticky status, and a rising edge does not.
- R7: With level-select=0 and any-edge=1, both rising and falling pin edges set a sticky status.
- R8: `irq_out` is 1 exactly when some line has both status and enable set. Status stays readable while its line is disabled.
- R9: Writing 1 to a clear bit resets that edge line's status. Clear bits always read 0. For a level line whose level is still active, a clear has no lasting effect.
- R10: If an edge is detected in the same cycle that a clear for that line is written, the status ends up set.
- R11: Writing all clear bits to 1 and all enable bits to 0 in one access drops `irq_out` to 0 and clears every edge line's status.
- R12: A pin change appears in the status bit after exactly three rising clock edges: two synchronizer stages and the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Write data for the control word |
| cfg_rdata | output | 32 | Current control and status word |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a fresh edge whose detection lands in the very cycle that software writes a clear for the same line. The bench drives the pin just after a falling clock edge and counts two rising edges through the synchronizer. It then raises the write strobe with the clear bit so that the write meets the edge at the status register. Exact three-edge latency is checked the same way, by sampling status one cycle before and at the cycle it is due. Both register packings are instantiated side by side and driven with the same stimulus. Each packing is checked against words assembled independently by the bench.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int LINES = 4;

    localparam int GRP_SENSE = 0;
    localparam int GRP_STAT  = 1;
    localparam int GRP_CLR   = 2;
    localparam int GRP_EN    = 3;
    localparam int GRP_ANY   = 4;
    localparam int GRP_LVL   = 5;
    localparam int GROUPS    = 6;

    typedef logic [LINES-1:0] lvec_t;

    typedef struct packed {
        lvec_t sense;
        lvec_t en;
        lvec_t any;
        lvec_t lvl;
        lvec_t stat;
    } irq_state_t;

    // bit position of the first line of a group for the chosen packing
    function automatic int grp_base(bit alt, int grp);
        return grp * (alt ? 5 : 4);
    endfunction

    function automatic lvec_t get_grp(logic [31:0] word, bit alt, int grp);
        lvec_t v;
        for (int i = 0; i < LINES; i++) begin
            v[i] = word[grp_base(alt, grp) + i];
        end
        return v;
    endfunction

    function automatic logic [31:0] pack_word(bit alt, irq_state_t s);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < LINES; i++) begin
            w[grp_base(alt, GRP_SENSE) + i] = s.sense[i];
            w[grp_base(alt, GRP_STAT)  + i] = s.stat[i];
            w[grp_base(alt, GRP_EN)    + i] = s.en[i];
            w[grp_base(alt, GRP_ANY)   + i] = s.any[i];
            w[grp_base(alt, GRP_LVL)   + i] = s.lvl[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic cur,
    output logic prev
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign cur  = chain_q[STAGES-1];
    assign prev = chain_q[STAGES];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
    input  logic cur,
    input  logic prev,
    input  logic sense,
    input  logic any,
    input  logic lvl,
    input  logic stat_q,
    input  logic clr,
    output logic stat_d
);
    logic rise, fall, hit;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (any)        hit = rise | fall;
        else if (sense) hit = rise;
        else            hit = fall;

        if (lvl) stat_d = (cur == sense);
        else     stat_d = hit | (stat_q & ~clr);   // new edge beats clear
    end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  lvec_t       stat_nxt,
    output irq_state_t  state,
    output logic [31:0] rdata
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_nxt;
        if (we) begin
            st_d.sense = get_grp(wdata, ALT_LAYOUT, GRP_SENSE);
            st_d.en    = get_grp(wdata, ALT_LAYOUT, GRP_EN);
            st_d.any   = get_grp(wdata, ALT_LAYOUT, GRP_ANY);
            st_d.lvl   = get_grp(wdata, ALT_LAYOUT, GRP_LVL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;
    assign rdata = pack_word(ALT_LAYOUT, st_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter bit ALT_LAYOUT  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  irq_pin,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq_out
);
    lvec_t      cur, prev, clr_vec, stat_nxt;
    irq_state_t state;

    assign clr_vec = cfg_we ? get_grp(cfg_wdata, ALT_LAYOUT, GRP_CLR) : '0;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (irq_pin[i]),
            .cur  (cur[i]),
            .prev (prev[i])
        );

        ext_irq_detect u_det (
            .cur   (cur[i]),
            .prev  (prev[i]),
            .sense (state.sense[i]),
            .any   (state.any[i]),
            .lvl   (state.lvl[i]),
            .stat_q(state.stat[i]),
            .clr   (clr_vec[i]),
            .stat_d(stat_nxt[i])
        );
    end

    ext_irq_regs #(.ALT_LAYOUT(ALT_LAYOUT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .stat_nxt(stat_nxt),
        .state   (state),
        .rdata   (cfg_rdata)
    );

    assign irq_out = |(state.stat & state.en);
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        irq_out
);
    function automatic logic [31:0] used_bits(bit alt);
        logic [31:0] m;
        m = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int i = 0; i < LINES; i++) m[grp_base(alt, g) + i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [31:0] USED = used_bits(ALT_LAYOUT);

    lvec_t r_stat, r_en, r_lvl;
    assign r_stat = get_grp(cfg_rdata, ALT_LAYOUT, GRP_STAT);
    assign r_en   = get_grp(cfg_rdata, ALT_LAYOUT, GRP_EN);
    assign r_lvl  = get_grp(cfg_rdata, ALT_LAYOUT, GRP_LVL);

    // R1
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~USED) == 32'h0);

    // R9
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        get_grp(cfg_rdata, ALT_LAYOUT, GRP_CLR) == '0);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (get_grp(cfg_rdata, ALT_LAYOUT, GRP_EN)
                        == get_grp($past(cfg_wdata), ALT_LAYOUT, GRP_EN)) &&
                   (get_grp(cfg_rdata, ALT_LAYOUT, GRP_LVL)
                        == get_grp($past(cfg_wdata), ALT_LAYOUT, GRP_LVL)) &&
                   (get_grp(cfg_rdata, ALT_LAYOUT, GRP_SENSE)
                        == get_grp($past(cfg_wdata), ALT_LAYOUT, GRP_SENSE)) &&
                   (get_grp(cfg_rdata, ALT_LAYOUT, GRP_ANY)
                        == get_grp($past(cfg_wdata), ALT_LAYOUT, GRP_ANY)));

    // R8
    irq_needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((r_stat & r_en) != '0));

    // R8
    irq_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_stat & r_en) != '0) |-> irq_out);

    for (genvar i = 0; i < LINES; i++) begin : g_sticky
        // R5
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_stat[i] && !r_lvl[i] && !cfg_we) |=> r_stat[i]);
    end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.ALT_LAYOUT(ALT_LAYOUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .irq_out  (irq_out)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    localparam int HALF = 2;   // 250 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_pin = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] wd_c = '0, wd_a = '0;
    logic [31:0] rd_c, rd_a;
    logic        irq_c, irq_a;

    always #HALF clk = ~clk;

    ext_irq_ctrl #(.ALT_LAYOUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_we(cfg_we),
        .cfg_wdata(wd_c), .cfg_rdata(rd_c), .irq_out(irq_c));

    ext_irq_ctrl #(.ALT_LAYOUT(1'b1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_we(cfg_we),
        .cfg_wdata(wd_a), .cfg_rdata(rd_a), .irq_out(irq_a));

    int checks = 0;
    int fails  = 0;

    // bench-side shadow of the configuration
    logic [3:0] s_sense = '0, s_en = '0, s_any = '0, s_lvl = '0;

    typedef struct {
        string      tag;
        logic [31:0] wc;
        logic [31:0] wa;
        logic        irq;
    } item_t;

    item_t sbq[$];
    event  sb_ev;

    // group order: sense, status, clear, enable, any-edge, level-select
    function automatic logic [31:0] mk(int stride, logic [3:0] se, logic [3:0] st,
                                       logic [3:0] cl, logic [3:0] en,
                                       logic [3:0] an, logic [3:0] lv);
        logic [31:0] w;
        logic [3:0]  f [6];
        w = '0;
        f[0] = se; f[1] = st; f[2] = cl; f[3] = en; f[4] = an; f[5] = lv;
        for (int g = 0; g < 6; g++)
            for (int i = 0; i < 4; i++) w[g*stride + i] = f[g][i];
        return w;
    endfunction

    task automatic expect_now(string tag, logic [3:0] st, logic irq);
        item_t it;
        it.tag = tag;
        it.wc  = mk(4, s_sense, st, 4'h0, s_en, s_any, s_lvl);
        it.wa  = mk(5, s_sense, st, 4'h0, s_en, s_any, s_lvl);
        it.irq = irq;
        sbq.push_back(it);
        -> sb_ev;
    endtask

    initial begin : monitor
        forever begin
            @(sb_ev);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if (rd_c !== it.wc || rd_a !== it.wa || irq_c !== it.irq || irq_a !== it.irq) begin
                    fails++;
                    $display("FAIL %s: rd=%h/%h irq=%b/%b expected rd=%h/%h irq=%b",
                             it.tag, rd_c, rd_a, irq_c, irq_a, it.wc, it.wa, it.irq);
                end
            end
        end
    end

    task automatic drive_write(logic [3:0] se, logic [3:0] en, logic [3:0] an,
                               logic [3:0] lv, logic [3:0] cl);
        s_sense = se; s_en = en; s_any = an; s_lvl = lv;
        wd_c   = mk(4, se, 4'hF, cl, en, an, lv);   // status group written as 1s: ignored
        wd_a   = mk(5, se, 4'hF, cl, en, an, lv);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_write(logic [3:0] se, logic [3:0] en, logic [3:0] an,
                            logic [3:0] lv, logic [3:0] cl);
        drive_write(se, en, an, lv, cl);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin : watchdog
        #(2*HALF*100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        expect_now("R1 reset value", 4'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 after release", 4'h0, 1'b0);

        // line0 level-high, line1 level-low, line2 rising, line3 falling
        do_write(4'b0101, 4'hF, 4'h0, 4'b0011, 4'h0);
        settle();
        expect_now("R2 R4 readback, low level active", 4'b0010, 1'b1);

        // R12 exact latency on line0
        irq_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R12 not yet after two edges", 4'b0010, 1'b1);
        @(negedge clk);
        expect_now("R12 R3 set at third edge", 4'b0011, 1'b1);
        irq_pin[0] = 1'b0;
        settle();
        expect_now("R3 follows level low", 4'b0010, 1'b1);

        irq_pin[1] = 1'b1;
        settle();
        expect_now("R4 inactive when high", 4'b0000, 1'b0);

        irq_pin[2] = 1'b1;
        settle();
        expect_now("R5 rising sets", 4'b0100, 1'b1);
        irq_pin[2] = 1'b0;
        settle();
        expect_now("R5 sticky after fall", 4'b0100, 1'b1);

        irq_pin[3] = 1'b1;
        settle();
        expect_now("R6 rise ignored", 4'b0100, 1'b1);
        irq_pin[3] = 1'b0;
        settle();
        expect_now("R6 falling sets", 4'b1100, 1'b1);

        do_write(4'b0101, 4'hF, 4'h0, 4'b0011, 4'b1100);
        expect_now("R9 clear edge lines", 4'b0000, 1'b0);

        irq_pin[0] = 1'b1;
        settle();
        do_write(4'b0101, 4'hF, 4'h0, 4'b0011, 4'b0001);
        settle();
        expect_now("R9 level clear no lasting effect", 4'b0001, 1'b1);

        do_write(4'b0101, 4'h0, 4'h0, 4'b0011, 4'h0);
        expect_now("R8 masked status visible, no irq", 4'b0001, 1'b0);
        do_write(4'b0101, 4'b1110, 4'h0, 4'b0011, 4'h0);
        expect_now("R8 other lines enabled only", 4'b0001, 1'b0);
        do_write(4'b0101, 4'b0001, 4'h0, 4'b0011, 4'h0);
        expect_now("R8 enabled line drives irq", 4'b0001, 1'b1);

        // line2 any-edge, enable all
        do_write(4'b0101, 4'hF, 4'b0100, 4'b0011, 4'h0);
        irq_pin[2] = 1'b1;
        settle();
        expect_now("R7 rising sets", 4'b0101, 1'b1);
        do_write(4'b0101, 4'hF, 4'b0100, 4'b0011, 4'b0100);
        expect_now("R7 cleared", 4'b0001, 1'b1);
        irq_pin[2] = 1'b0;
        settle();
        expect_now("R7 falling sets", 4'b0101, 1'b1);

        // R10: clear written in the cycle the new edge is registered
        do_write(4'b0101, 4'hF, 4'b0100, 4'b0011, 4'b0100);
        settle();
        expect_now("R10 pre-clear", 4'b0001, 1'b1);
        irq_pin[2] = 1'b1;
        repeat (2) @(negedge clk);
        drive_write(4'b0101, 4'hF, 4'b0100, 4'b0011, 4'b0100);
        expect_now("R10 edge beats clear", 4'b0101, 1'b1);

        // R11: clear all, disable all
        irq_pin[3] = 1'b1;
        settle();
        irq_pin[3] = 1'b0;
        settle();
        expect_now("R11 before quiesce", 4'b1101, 1'b1);
        do_write(4'b0101, 4'h0, 4'b0100, 4'b0011, 4'hF);
        expect_now("R11 quiesced", 4'b0001, 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule